// File: doc/BRIEF.md
# I2C Register Slave with Write-Acknowledge Clock Stretching

This block is a serial-bus slave that gives a host write and read access to an 8-bit-addressed register space. A transfer opens with a START and the device address. A write then carries a subaddress byte followed by any number of data bytes. A read uses a repeated START with the read address and streams bytes out from the current subaddress. The subaddress pointer advances by one after every data byte in either direction. The register storage itself sits outside the block. Writes leave through a request/done handshake. Reads are served from a combinational read port that the block addresses with its pointer.

After each written data byte has been acknowledged, the slave holds SCL low. It releases SCL only when the internal consumer reports completion, so the host cannot start the next byte or the STOP while the consumer is busy. A fixed set of subaddresses belongs to a long-wait class, because writing them restarts internal initialization. Each class has its own timeout, after which SCL is released even if completion never arrives. The 7-bit device address is chosen by a strap input that is latched while reset is asserted. Bus traffic seen during reset is ignored. Both bus lines pass through a two-flop synchronizer and a glitch filter before any decoding. Both lines are driven open-drain: the block only drives them low.

Top module: `i2c_stretch_slave`

## Requirements
- R1: The device address is 7'h5C (write byte 8'hB8, read byte 8'hB9) when `addr_strap` is low at the last clock of reset, and 7'h5D (8'hBA / 8'hBB) when it is high. Changing the strap after reset has no effect.
- R2: A matching address byte is acknowledged by SDA pulled low during the ninth clock. A non-matching address is not acknowledged, and every later byte up to the next START is ignored: no ACK and no write request.
- R3: In a write, the first byte after the address loads the subaddress. Each following data byte is presented on `reg_wr_addr`/`reg_wr_data` at the current subaddress, and the subaddress then advances by one, wrapping from 8'hFF to 8'h00.
- R4: After the ACK clock of every data byte, `reg_wr_req` rises and SCL is held low for as long as the request is high. When `reg_wr_done` is seen high, the request drops at the next clock edge, so a done given in the (d+1)th request cycle gives a request exactly d+1 cycles long.
- R5: `reg_wr_slow` is 1 during a request whose subaddress is 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h28, 8'h2E or 8'h2F, and 0 for every other subaddress.
- R6: If done never arrives, the request and the SCL hold end after exactly FAST_WAIT cycles for a normal subaddress and SLOW_WAIT cycles for a long-wait subaddress. The subaddress still advances.
- R7: A read address byte, acknowledged, is followed by the byte at the current subaddress, sent MSB first, and the pointer advances by one per byte sent. A master ACK fetches the next byte. A master NACK ends the read, and a later read continues from the advanced pointer.
- R8: While `rst_n` is low the slave never drives SCL or SDA and never raises a write request. On leaving reset all outputs are inactive.
- R9: The slave changes its SDA drive only while SCL is low. Pulses on SCL or SDA shorter than FILT_LEN clocks are not seen as bus events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Device-address select, latched during reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or read data zero) |
| reg_wr_req | output | 1 | Write request to the register consumer |
| reg_wr_addr | output | 8 | Subaddress of the pending write |
| reg_wr_data | output | 8 | Data of the pending write |
| reg_wr_slow | output | 1 | Pending write belongs to the long-wait class |
| reg_wr_done | input | 1 | Consumer has accepted the pending write |
| reg_rd_addr | output | 8 | Current subaddress, for the read port |
| reg_rd_data | input | 8 | Register value at `reg_rd_addr` |

## Verification
A bus edge takes 2 synchronizer cycles plus FILT_LEN filter cycles to reach the decoder, and the SDA drive responds one cycle after that. The bench master holds each SCL phase for 25 clocks and samples SDA in the middle of the high phase, well clear of that latency. Write requests are due about six cycles after the ACK clock falls. Their length is exactly d+1 cycles for a done given in request cycle d+1, or exactly the class timeout, and a monitor counts the length at falling clock edges so that it can be compared exactly. Address, data and class are captured in the first request cycle and checked after the STOP, together with the ACK bits and the read bytes that the bus master sampled.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_SUB, ST_SACK,
    ST_WDAT, ST_DACK, ST_HOLD, ST_RDAT, ST_RACK
  } i2c_st_e;

  // 7-bit device address picked by the strap level
  function automatic logic [6:0] dev_addr7(input logic strap);
    return strap ? 7'h5D : 7'h5C;
  endfunction

  // subaddresses whose write restarts internal initialization
  function automatic logic long_wait_class(input logic [7:0] sub);
    case (sub)
      8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h28, 8'h2E, 8'h2F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        line_o <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_wait_timer.sv
module i2c_wait_timer #(
  parameter int FAST_WAIT = 12800,
  parameter int SLOW_WAIT = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic slow_i,
  output logic expired_o
);
  localparam int CW = $clog2(SLOW_WAIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit     = slow_i ? CW'(SLOW_WAIT) : CW'(FAST_WAIT);
  assign expired_o = run_i && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave #(
  parameter int FILT_LEN  = 3,
  parameter int FAST_WAIT = 12800,
  parameter int SLOW_WAIT = 131072
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_strap,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       reg_wr_req,
  output logic [7:0] reg_wr_addr,
  output logic [7:0] reg_wr_data,
  output logic       reg_wr_slow,
  input  logic       reg_wr_done,
  output logic [7:0] reg_rd_addr,
  input  logic [7:0] reg_rd_data
);
  import i2c_stretch_pkg::*;

  localparam int BYTE_BITS = 8;
  localparam int BCW       = $clog2(BYTE_BITS + 1);

  // filtered bus lines: index 1 is SCL, index 0 is SDA
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  logic scl_f, sda_f, scl_p, sda_p;
  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  // named bus events
  logic scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign bus_start = scl_f & scl_p & sda_p & ~sda_f;
  assign bus_stop  = scl_f & scl_p & ~sda_p & sda_f;

  // strap follows the pin while in reset, frozen afterwards
  logic strap_q;
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= addr_strap;
  end

  i2c_st_e        st;
  logic [BCW-1:0] bit_cnt;
  logic [7:0]     rx_sh, tx_sh, sub_q, wdat_q;
  logic           rw_q, nack_q, sda_oe_q;

  logic byte_end, addr_hit, addr_miss, wait_expired, wait_done, in_hold;
  assign byte_end  = scl_fall && (bit_cnt == BCW'(BYTE_BITS));
  assign addr_hit  = (rx_sh[7:1] == dev_addr7(strap_q));
  assign addr_miss = (st == ST_ADDR) && byte_end && !addr_hit;
  assign in_hold   = (st == ST_HOLD);
  assign wait_done = reg_wr_done || wait_expired;

  i2c_wait_timer #(.FAST_WAIT(FAST_WAIT), .SLOW_WAIT(SLOW_WAIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (in_hold),
    .slow_i    (reg_wr_slow),
    .expired_o (wait_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      sub_q    <= '0;
      wdat_q   <= '0;
      rw_q     <= 1'b0;
      nack_q   <= 1'b1;
      sda_oe_q <= 1'b0;
    end else if (!in_hold && bus_start) begin
      st       <= ST_ADDR;
      bit_cnt  <= '0;
      sda_oe_q <= 1'b0;
    end else if (!in_hold && bus_stop) begin
      st       <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      if (scl_rise) begin
        rx_sh  <= {rx_sh[6:0], sda_f};
        nack_q <= sda_f;
        if (bit_cnt != BCW'(BYTE_BITS)) bit_cnt <= bit_cnt + 1'b1;
      end
      case (st)
        ST_ADDR: if (byte_end) begin
          if (addr_hit) begin
            st       <= ST_AACK;
            rw_q     <= rx_sh[0];
            sda_oe_q <= 1'b1;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_AACK: if (scl_fall) begin
          if (rw_q) begin
            tx_sh    <= reg_rd_data;
            sda_oe_q <= ~reg_rd_data[7];
            sub_q    <= sub_q + 8'd1;
            bit_cnt  <= '0;
            st       <= ST_RDAT;
          end else begin
            sda_oe_q <= 1'b0;
            bit_cnt  <= '0;
            st       <= ST_SUB;
          end
        end
        ST_SUB: if (byte_end) begin
          sub_q    <= rx_sh;
          sda_oe_q <= 1'b1;
          st       <= ST_SACK;
        end
        ST_SACK: if (scl_fall) begin
          sda_oe_q <= 1'b0;
          bit_cnt  <= '0;
          st       <= ST_WDAT;
        end
        ST_WDAT: if (byte_end) begin
          wdat_q   <= rx_sh;
          sda_oe_q <= 1'b1;
          st       <= ST_DACK;
        end
        ST_DACK: if (scl_fall) begin
          sda_oe_q <= 1'b0;
          st       <= ST_HOLD;
        end
        ST_HOLD: if (wait_done) begin
          sub_q   <= sub_q + 8'd1;
          bit_cnt <= '0;
          st      <= ST_WDAT;
        end
        ST_RDAT: if (scl_fall) begin
          if (bit_cnt == BCW'(BYTE_BITS)) begin
            sda_oe_q <= 1'b0;
            st       <= ST_RACK;
          end else begin
            tx_sh    <= {tx_sh[6:0], 1'b0};
            sda_oe_q <= ~tx_sh[6];
          end
        end
        ST_RACK: if (scl_fall) begin
          if (!nack_q) begin
            tx_sh    <= reg_rd_data;
            sda_oe_q <= ~reg_rd_data[7];
            sub_q    <= sub_q + 8'd1;
            bit_cnt  <= '0;
            st       <= ST_RDAT;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign scl_oe      = in_hold;
  assign sda_oe      = sda_oe_q;
  assign reg_wr_req  = in_hold;
  assign reg_wr_addr = sub_q;
  assign reg_wr_data = wdat_q;
  assign reg_wr_slow = long_wait_class(sub_q);
  assign reg_rd_addr = sub_q;

endmodule

// File: rtl/i2c_stretch_slave_chk.sv
module i2c_stretch_slave_chk #(
  parameter int SLOW_WAIT = 131072
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       reg_wr_req,
  input logic       reg_wr_done,
  input logic       wait_expired,
  input logic [7:0] sub_q,
  input logic       addr_miss
);
  int hold_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_cnt <= 0;
    else if (scl_oe) hold_cnt <= hold_cnt + 1;
    else             hold_cnt <= 0;
  end

  // R2: a missed address never receives an ACK
  p_addr_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe);

  // R3: finishing a write advances the subaddress by one
  p_sub_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_req && (reg_wr_done || wait_expired)) |=> (sub_q == $past(sub_q) + 8'd1));

  // R4: request stays up until done or timeout
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_req && !reg_wr_done && !wait_expired) |=> reg_wr_req);

  // R4: the request starts while the bus clock is already low
  p_req_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_wr_req) |-> !scl_f);

  // R6: no hold outlasts the long-wait timeout
  p_hold_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= SLOW_WAIT);

  // R9: SDA drive changes only after SCL was seen low
  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_f));
endmodule

bind i2c_stretch_slave i2c_stretch_slave_chk #(.SLOW_WAIT(SLOW_WAIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_f        (scl_f),
  .sda_oe       (sda_oe),
  .scl_oe       (scl_oe),
  .reg_wr_req   (reg_wr_req),
  .reg_wr_done  (reg_wr_done),
  .wait_expired (wait_expired),
  .sub_q        (sub_q),
  .addr_miss    (addr_miss)
);

// File: tb/i2c_stretch_slave_bench.sv
`timescale 1ns/1ps
module i2c_stretch_slave_bench;
  localparam int FAST = 200;
  localparam int SLOW = 900;
  localparam int Q    = 25;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b1;
  logic strap = 1'b1;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic glitch = 1'b0;

  logic       scl_oe, sda_oe, reg_wr_req, reg_wr_slow, reg_wr_done;
  logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;
  logic       scl_bus, sda_bus;
  assign scl_bus = !(m_scl_low || scl_oe);
  assign sda_bus = !(m_sda_low || sda_oe);

  logic [7:0] mem [256];
  int dly [64];
  int wn = 0, dcnt = 0, cur = 0, hold_bad = 0, r9_bad = 0;
  logic [7:0] la [64], ld [64];
  logic       ls [64];
  int         ll [64];
  logic       req_q = 1'b0, soe_q = 1'b0;
  int nchk = 0, nerr = 0;
  logic [7:0] wbuf [8];
  int         dbuf [8];

  assign reg_wr_done = reg_wr_req && (dly[wn[5:0]] >= 0) && (dcnt == dly[wn[5:0]]);
  assign reg_rd_data = mem[reg_rd_addr];

  i2c_stretch_slave #(.FILT_LEN(3), .FAST_WAIT(FAST), .SLOW_WAIT(SLOW)) u_i2c_stretch_slave (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr_req(reg_wr_req), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_wr_slow(reg_wr_slow), .reg_wr_done(reg_wr_done),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic exp_slow(input logic [7:0] a);
    return (a >= 8'h04 && a <= 8'h08) || a == 8'h28 || a == 8'h2E || a == 8'h2F;
  endfunction

  // consumer model
  always @(posedge clk) begin
    if (reg_wr_req) dcnt <= dcnt + 1; else dcnt <= 0;
    if (reg_wr_done) mem[reg_wr_addr] <= reg_wr_data;
  end

  // write monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (reg_wr_req) begin
      if (!req_q) begin
        la[wn[5:0]] = reg_wr_addr;
        ld[wn[5:0]] = reg_wr_data;
        ls[wn[5:0]] = reg_wr_slow;
        cur = 0;
      end
      cur = cur + 1;
      if (scl_bus) hold_bad = hold_bad + 1;
    end else if (req_q) begin
      ll[wn[5:0]] = cur;
      wn = wn + 1;
    end
    req_q = reg_wr_req;
    if (rst_n && (sda_oe !== soe_q) && scl_bus) r9_bad = r9_bad + 1;
    soe_q = sda_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wait_hi();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b1; qw(); m_scl_low = 1'b1; qw();
  endtask

  task automatic bus_rstart();
    m_sda_low = 1'b0; qw(); m_scl_low = 1'b0; wait_hi(); qw();
    m_sda_low = 1'b1; qw(); m_scl_low = 1'b1; qw();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; qw(); m_scl_low = 1'b0; wait_hi(); qw();
    m_sda_low = 1'b0; qw();
  endtask

  task automatic send_bit(input logic b);
    m_sda_low = !b; qw();
    if (glitch) begin m_scl_low = 1'b0; @(negedge clk); m_scl_low = 1'b1; end
    m_scl_low = 1'b0; wait_hi(); qw();
    if (glitch && b) begin m_sda_low = 1'b1; @(negedge clk); m_sda_low = 1'b0; end
    qw(); m_scl_low = 1'b1; qw();
  endtask

  task automatic recv_bit(output logic b);
    m_sda_low = 1'b0; qw(); m_scl_low = 1'b0; wait_hi(); qw();
    b = sda_bus; qw(); m_scl_low = 1'b1; qw();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(!ack);
  endtask

  task automatic do_write(input logic [7:0] sub, input int n);
    int w0;
    logic ack;
    logic [7:0] a;
    w0 = wn;
    for (int k = 0; k < n; k++) dly[(w0 + k) % 64] = dbuf[k];
    bus_start();
    wr_byte(8'hBA, ack); chk("R1 address ack", int'(ack), 1);
    wr_byte(sub, ack);   chk("R2 subaddress ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      wr_byte(wbuf[k], ack); chk("R2 data ack", int'(ack), 1);
    end
    bus_stop();
    repeat (10) @(negedge clk);
    chk("R3 write count", wn - w0, n);
    for (int k = 0; k < n; k++) begin
      a = sub + 8'(k);
      chk("R3 write address", int'(la[w0 + k]), int'(a));
      chk("R3 write data", int'(ld[w0 + k]), int'(wbuf[k]));
      chk("R5 wait class", int'(ls[w0 + k]), int'(exp_slow(a)));
      if (dbuf[k] < 0) chk("R6 timeout length", ll[w0 + k], exp_slow(a) ? SLOW : FAST);
      else             chk("R4 request length", ll[w0 + k], dbuf[k] + 1);
    end
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    logic [7:0] sub;
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    for (int i = 0; i < 64; i++) dly[i] = 0;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R8: traffic during reset is ignored
    bus_start();
    wr_byte(8'hBA, ack);
    chk("R8 no ack in reset", int'(ack), 0);
    bus_stop();
    chk("R8 no write in reset", wn, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    strap = 1'b0;
    chk("R8 scl_oe after reset", int'(scl_oe), 0);
    chk("R8 sda_oe after reset", int'(sda_oe), 0);
    chk("R8 req after reset", int'(reg_wr_req), 0);

    // R1/R2: other address refused, rest of transfer ignored
    bus_start();
    wr_byte(8'hB8, ack); chk("R1 strap-low address refused", int'(ack), 0);
    wr_byte(8'h10, ack); chk("R2 ignored after nack", int'(ack), 0);
    wr_byte(8'h55, ack); chk("R2 ignored after nack", int'(ack), 0);
    bus_stop();
    chk("R2 no write after nack", wn, 0);

    // R3/R4 basic write with varied completion delays
    wbuf[0] = 8'hA1; wbuf[1] = 8'h5E; wbuf[2] = 8'h0C;
    dbuf[0] = 5; dbuf[1] = 37; dbuf[2] = 0;
    do_write(8'h10, 3);

    // R7 read back with repeated start
    bus_start();
    wr_byte(8'hBA, ack); wr_byte(8'h10, ack);
    bus_rstart();
    wr_byte(8'hBB, ack); chk("R7 read address ack", int'(ack), 1);
    rd_byte(1'b1, v); chk("R7 read byte 0", int'(v), 8'hA1);
    rd_byte(1'b1, v); chk("R7 read byte 1", int'(v), 8'h5E);
    rd_byte(1'b0, v); chk("R7 read byte 2", int'(v), 8'h0C);
    bus_stop();
    bus_start();
    wr_byte(8'hBB, ack); chk("R7 second read ack", int'(ack), 1);
    rd_byte(1'b0, v); chk("R7 pointer continues", int'(v), int'(init_val(8'h13)));
    bus_stop();

    // R5 class boundaries
    for (int k = 0; k < 6; k++) begin wbuf[k] = 8'(k * 17 + 3); dbuf[k] = k * 3; end
    do_write(8'h03, 6);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; dbuf[0] = 2; dbuf[1] = 9;
    do_write(8'h27, 2);
    wbuf[0] = 8'h33; wbuf[1] = 8'h44; wbuf[2] = 8'h55; dbuf[0] = 1; dbuf[1] = 1; dbuf[2] = 60;
    do_write(8'h2D, 3);

    // R6 timeouts, normal and long class
    wbuf[0] = 8'h66; wbuf[1] = 8'h77; dbuf[0] = -1; dbuf[1] = 4;
    do_write(8'h40, 2);
    wbuf[0] = 8'h88; dbuf[0] = -1;
    do_write(8'h07, 1);

    // R3 wrap of the pointer
    wbuf[0] = 8'h99; wbuf[1] = 8'hAA; dbuf[0] = 3; dbuf[1] = 3;
    do_write(8'hFF, 2);

    // R9 short pulses on both lines
    glitch = 1'b1;
    wbuf[0] = 8'hA5; wbuf[1] = 8'hFF; dbuf[0] = 7; dbuf[1] = 2;
    do_write(8'h60, 2);
    glitch = 1'b0;

    // random transfers
    for (int t = 0; t < 6; t++) begin
      sub = 8'($urandom % 256);
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < n; k++) begin
        wbuf[k] = 8'($urandom % 256);
        dbuf[k] = int'($urandom % 120);
      end
      do_write(sub, n);
    end

    chk("R4 SCL low while request", hold_bad, 0);
    chk("R9 SDA edge while SCL high", r9_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule